// File: doc/BRIEF.md
# Flash Program/Erase Protection Guard

This block decides, cycle by cycle, which operations an on-chip flash array may perform. It watches a chip reset, a hardware-standby level, a software-standby level, the program and erase mode requests, and a one-cycle pulse from the error-detection logic. From these it drives four registered permissions: read enable, program/erase enable, a sticky error flag, and a clear signal that sends the program/erase control registers back to their initial values.

In normal operation the block sits in a read state. A program or erase request opens the program/erase state, where reads are blocked. An error pulse seen there moves the block into a protected state. In that state reads come back, writing stays locked, and the error flag stays set. The protection survives software standby. During software standby everything is blocked, and the flag stays set. Only reset or hardware standby clears the protection; releasing them brings the block up in the read state.

All pins are plain control levels or pulses. No data passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `fpe_guard`

## Requirements
- R1: While `rst_n` is low (asynchronously) or `hw_standby` is high (at the next clock edge), the block is in hardware protection: `rd_en`=0, `pe_en`=0, `err_flag`=0, `iface_clr`=1.
- R2: On the first edge with `rst_n` high and `hw_standby` low after hardware protection, the block enters the read state (`rd_en`=1, others 0). Any pending mode request is not honoured on that edge.
- R3: In the read state, with `sw_standby` low, a high `prog_req` or `erase_req` gives the program/erase state (`pe_en`=1, `rd_en`=0, `err_flag`=0, `iface_clr`=0). When both requests are low there, the block returns to the read state.
- R4: `err_pulse` in the program/erase state gives the error-protected state (`rd_en`=1, `pe_en`=0, `err_flag`=1, `iface_clr`=0). `err_pulse` in any other state has no effect.
- R5: In the error-protected state and in its standby variant, `prog_req` and `erase_req` are ignored.
- R6: `sw_standby` high in the error-protected state gives error standby (`rd_en`=0, `pe_en`=0, `err_flag`=1, `iface_clr`=0). Dropping it returns the block to the error-protected state.
- R7: `sw_standby` high in the read or program/erase state, with no error pulse, gives plain standby (`rd_en`=0, `pe_en`=0, `err_flag`=0, `iface_clr`=1). Mode requests are ignored there. Dropping it returns the block to the read state.
- R8: Reset and hardware standby take priority over a simultaneous `err_pulse`, `sw_standby` or mode request.
- R9: All four outputs are registered. They change only on the clock edge that samples the causing input, never between edges, except for the asynchronous reset.
- R10: In the program/erase state, `err_pulse` wins over a simultaneous `sw_standby` and leads to the error-protected state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_standby | input | 1 | Hardware standby level, active high |
| sw_standby | input | 1 | Software standby level, active high |
| prog_req | input | 1 | Program mode request level |
| erase_req | input | 1 | Erase mode request level |
| err_pulse | input | 1 | One-cycle program/erase error indication |
| rd_en | output | 1 | Flash reads permitted |
| pe_en | output | 1 | Programming/erasing permitted |
| err_flag | output | 1 | Sticky error flag |
| iface_clr | output | 1 | Return program/erase control registers to initial state |

## Verification
The two functions that can collide in one cycle are error capture and standby entry (or, above both, hardware protection). The bench drives `err_pulse` together with `sw_standby` while programming. It expects the error-protected outputs on that edge and error standby on the next edge. It also asserts reset or hardware standby on the same edge as an error pulse and judges that hardware protection wins with `err_flag` at 0.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  typedef enum logic [2:0] {
    ST_HWPROT  = 3'd0,
    ST_READ    = 3'd1,
    ST_PROG    = 3'd2,
    ST_ERASE   = 3'd3,
    ST_ERRPROT = 3'd4,
    ST_ERRSTBY = 3'd5,
    ST_SWSTBY  = 3'd6
  } fpe_state_e;

  typedef struct packed {
    logic rd_en;
    logic pe_en;
    logic err_flag;
    logic iface_clr;
  } fpe_perm_t;

  localparam fpe_perm_t PERM_HWPROT = '{rd_en: 1'b0, pe_en: 1'b0, err_flag: 1'b0, iface_clr: 1'b1};
endpackage

// File: rtl/fpe_next.sv
module fpe_next
  import fpe_pkg::*;
#(
  parameter bit PROG_FIRST = 1'b1
) (
  input  fpe_state_e cur,
  input  logic       hw_standby,
  input  logic       sw_standby,
  input  logic       prog_req,
  input  logic       erase_req,
  input  logic       err_pulse,
  output fpe_state_e nxt
);
  fpe_state_e mode_pick;

  generate
    if (PROG_FIRST) begin : g_prog_first
      always_comb mode_pick = prog_req ? ST_PROG : ST_ERASE;
    end else begin : g_erase_first
      always_comb mode_pick = erase_req ? ST_ERASE : ST_PROG;
    end
  endgenerate

  always_comb begin
    nxt = cur;
    if (hw_standby) begin
      nxt = ST_HWPROT;                       // R8: overrides everything
    end else begin
      unique case (cur)
        ST_HWPROT:  nxt = ST_READ;           // R2
        ST_READ: begin
          if (sw_standby)                 nxt = ST_SWSTBY;
          else if (prog_req || erase_req) nxt = mode_pick;
          else                            nxt = ST_READ;
        end
        ST_PROG, ST_ERASE: begin
          if (err_pulse)                  nxt = ST_ERRPROT;  // R10: before standby
          else if (sw_standby)            nxt = ST_SWSTBY;
          else if (prog_req || erase_req) nxt = mode_pick;
          else                            nxt = ST_READ;
        end
        ST_ERRPROT: nxt = sw_standby ? ST_ERRSTBY : ST_ERRPROT;
        ST_ERRSTBY: nxt = sw_standby ? ST_ERRSTBY : ST_ERRPROT;
        ST_SWSTBY:  nxt = sw_standby ? ST_SWSTBY  : ST_READ;
        default:    nxt = ST_HWPROT;
      endcase
    end
  end
endmodule

// File: rtl/fpe_decode.sv
module fpe_decode
  import fpe_pkg::*;
(
  input  fpe_state_e st,
  output fpe_perm_t  perm
);
  always_comb begin
    perm = PERM_HWPROT;
    unique case (st)
      ST_READ:           perm = '{rd_en: 1'b1, pe_en: 1'b0, err_flag: 1'b0, iface_clr: 1'b0};
      ST_PROG, ST_ERASE: perm = '{rd_en: 1'b0, pe_en: 1'b1, err_flag: 1'b0, iface_clr: 1'b0};
      ST_ERRPROT:        perm = '{rd_en: 1'b1, pe_en: 1'b0, err_flag: 1'b1, iface_clr: 1'b0};
      ST_ERRSTBY:        perm = '{rd_en: 1'b0, pe_en: 1'b0, err_flag: 1'b1, iface_clr: 1'b0};
      ST_SWSTBY:         perm = '{rd_en: 1'b0, pe_en: 1'b0, err_flag: 1'b0, iface_clr: 1'b1};
      default:           perm = PERM_HWPROT;
    endcase
  end
endmodule

// File: rtl/fpe_guard.sv
module fpe_guard
  import fpe_pkg::*;
#(
  parameter bit PROG_FIRST = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_standby,
  input  logic sw_standby,
  input  logic prog_req,
  input  logic erase_req,
  input  logic err_pulse,
  output logic rd_en,
  output logic pe_en,
  output logic err_flag,
  output logic iface_clr
);
  fpe_state_e state_q, state_d;
  fpe_perm_t  perm_q, perm_d;

  fpe_next #(.PROG_FIRST(PROG_FIRST)) u_next (
    .cur        (state_q),
    .hw_standby (hw_standby),
    .sw_standby (sw_standby),
    .prog_req   (prog_req),
    .erase_req  (erase_req),
    .err_pulse  (err_pulse),
    .nxt        (state_d)
  );

  // Decode the next state so the permissions move on the same edge as the state.
  fpe_decode u_decode (
    .st   (state_d),
    .perm (perm_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HWPROT;
      perm_q  <= PERM_HWPROT;
    end else begin
      state_q <= state_d;
      perm_q  <= perm_d;
    end
  end

  assign rd_en     = perm_q.rd_en;
  assign pe_en     = perm_q.pe_en;
  assign err_flag  = perm_q.err_flag;
  assign iface_clr = perm_q.iface_clr;
endmodule

// File: rtl/fpe_guard_chk.sv
module fpe_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic hw_standby,
  input logic sw_standby,
  input logic err_pulse,
  input logic rd_en,
  input logic pe_en,
  input logic err_flag,
  input logic iface_clr
);
  AST_HW_FORCES_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    hw_standby |=> (!rd_en && !pe_en && !err_flag && iface_clr));              // R1
  AST_RD_PE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && pe_en));                                                        // R3
  AST_ERR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_en && err_pulse && !hw_standby) |=> (err_flag && rd_en && !pe_en));    // R4
  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(pe_en && err_pulse));                            // R4
  AST_NO_PE_IN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> !pe_en);                                                      // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !hw_standby) |=> err_flag);                                   // R6
  AST_ERR_STBY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && sw_standby && !hw_standby) |=> (err_flag && !rd_en && !pe_en)); // R6
endmodule

bind fpe_guard fpe_guard_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hw_standby (hw_standby),
  .sw_standby (sw_standby),
  .err_pulse  (err_pulse),
  .rd_en      (rd_en),
  .pe_en      (pe_en),
  .err_flag   (err_flag),
  .iface_clr  (iface_clr)
);

// File: tb/tb_fpe_guard.sv
`timescale 1ns/100ps
module tb_fpe_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0, hw_standby = 1'b0, sw_standby = 1'b0;
  logic prog_req = 1'b0, erase_req = 1'b0, err_pulse = 1'b0;
  logic rd_en, pe_en, err_flag, iface_clr;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fpe_guard dut (.*);

  // Vector: {rst_n, hw, sw, prog, erase, err, exp_rd, exp_pe, exp_err, exp_clr}
  localparam int NV = 28;
  localparam logic [9:0] VEC [NV] = '{
    10'b0_00000_0001, // 0  R1 reset
    10'b1_00000_1000, // 1  R2 release
    10'b1_00001_1000, // 2  R4 error in read ignored
    10'b1_00100_0100, // 3  R3 program
    10'b1_00000_1000, // 4  R3 back to read
    10'b1_00010_0100, // 5  R3 erase
    10'b1_00011_1010, // 6  R4 error while erasing
    10'b1_00100_1010, // 7  R5 program ignored
    10'b1_00010_1010, // 8  R5 erase ignored
    10'b1_01000_0010, // 9  R6 error standby
    10'b1_01100_0010, // 10 R5 request ignored in error standby
    10'b1_00000_1010, // 11 R6 leave standby, still flagged
    10'b1_10001_0001, // 12 R8 hw standby beats error
    10'b1_00100_1000, // 13 R2 release ignores request
    10'b1_00100_0100, // 14 R3 program
    10'b1_01000_0001, // 15 R7 standby from program
    10'b1_01100_0001, // 16 R7 request ignored
    10'b1_00000_1000, // 17 R7 back to read
    10'b1_01000_0001, // 18 R7 standby from read
    10'b1_00000_1000, // 19 R7 back to read
    10'b1_00110_0100, // 20 R3 both requests
    10'b1_01101_1010, // 21 R10 error and standby together
    10'b1_01000_0010, // 22 R6 then error standby
    10'b1_11000_0001, // 23 R1 hw standby clears protection
    10'b1_00000_1000, // 24 R2
    10'b1_00010_0100, // 25 R3
    10'b0_00011_0001, // 26 R8 reset beats error
    10'b1_00000_1000  // 27 R2
  };
  localparam int VREQ [NV] = '{1,2,4,3,3,3,4,5,5,6,5,6,8,2,3,7,7,7,7,7,3,10,6,1,2,3,8,2};

  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {rd_en, pe_en, err_flag, iface_clr};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs {rd,pe,err,clr} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] v);
    {rst_n, hw_standby, sw_standby, prog_req, erase_req, err_pulse} = v;
  endtask

  task automatic step(input logic [5:0] v);
    @(negedge clk);
    drive(v);
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][9:4]);
      check($sformatf("R%0d vector %0d", VREQ[i], i), VEC[i][3:0]);
    end

    // R1: asynchronous reset acts between edges
    step(6'b1_00100);
    check("R3 program before async reset", 4'b0100);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", 4'b0001);

    // R1/R8: long hardware standby with requests and errors held
    step(6'b1_00000);
    step(6'b1_00010);
    check("R3 erase", 4'b0100);
    for (int k = 0; k < 20; k++) begin
      step(6'b1_11111);
      check("R8 hw standby held", 4'b0001);
    end
    step(6'b1_00000);
    check("R2 release", 4'b1000);

    // R9: the flag does not move before the sampling edge
    step(6'b1_00100);
    @(negedge clk);
    err_pulse = 1'b1;
    #1;
    check("R9 before edge", 4'b0100);
    @(posedge clk);
    #1;
    check("R9 after edge", 4'b1010);
    step(6'b1_00000);
    check("R4 pulse gone, flag stays", 4'b1010);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule